// File: doc/BRIEF.md
# Windowed Register Access Sequencer

This block sits on the host side of a link whose memory aperture is only 1 MB wide, while the device behind it exposes a 32 MB register space. It takes 32-bit read and write requests, each tagged with a 25-bit device offset, and turns every request into the short series of bus transactions needed to reach that offset. Offsets in the low half of the aperture are reached directly. Higher offsets are reached through a sliding window in the upper half of the aperture, which is selected by a window control register inside the device.

Before a windowed access the sequencer programs the window register and reads it back to confirm the write. A mismatch raises a sticky error flag, and the access goes ahead anyway. The sequencer keeps a copy of the window it last programmed and skips reprogramming when the next windowed access falls in the same window. A build parameter turns that cache off, so that every windowed access programs and confirms the window again. A configuration input turns windowing off entirely, and every offset then goes out unchanged as a single access.

Requests use a valid/ready handshake. A one-cycle response pulse carries the read data. The bus side is a simple master: it holds one transaction, and it keeps that transaction steady until the slave signals completion.

Top module: `win_access_seq`

## Requirements
- R1: When `win_en` is 0, or when the offset is below 0x80000, the request becomes exactly one bus access. That access uses the request's offset unchanged as `bus_addr`, with the request's direction and write data.
- R2: For any other offset, the window number is offset[24:19] (offset >> 19, 6 bits). Programming the window is a bus write to address 0x310C whose data is bit 30 set ORed with the window number in bits 5:0.
- R3: Every window write is followed at once by a bus read of 0x310C. If the read data differs from the value written, `err_flag` rises, and the data access is still issued.
- R4: `err_flag` is 0 after reset. Once set, it stays set until `err_clr` is high at a clock edge.
- R5: With CACHE_EN=1, a windowed access whose window equals the window last programmed skips the write and the readback. It issues only the data access.
- R6: With CACHE_EN=0, every windowed access performs the write and the readback, even when the window is unchanged.
- R7: The data access of a windowed request goes to address 0x80000 + (offset & 0x7FFFF). It uses the request's direction and write data.
- R8: After reset no window is cached, so the first windowed access always programs the window.
- R9: `req_ready` is high only while the sequencer is idle, and no bus transaction starts until the previous request has finished. `rsp_valid` pulses for one cycle after the final data access completes. For a read, `rsp_rdata` holds the bus data of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Enables windowed addressing of high offsets |
| err_clr | input | 1 | Clears the sticky error flag |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Device offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data of the completed read |
| err_flag | output | 1 | Sticky window-confirm mismatch flag |
| bus_valid | output | 1 | Bus transaction active; held until bus_done |
| bus_write | output | 1 | Bus transaction direction |
| bus_addr | output | 25 | Bus address (aperture offset, or device offset when windowing is off) |
| bus_wdata | output | 32 | Bus write data |
| bus_done | input | 1 | Slave completes the current transaction this cycle |
| bus_rdata | input | 32 | Slave read data, valid with bus_done |

## Verification
The bench builds two instances side by side. The first uses the default CACHE_EN=1, which covers cache hits, cache misses after a window change, the first access after reset, and the mode with windowing switched off. The second uses CACHE_EN=0. Repeating a windowed access in the same window on that instance shows the window being written and confirmed again, which the cached build cannot show. The bus model can corrupt the readback of the window register, so a confirm mismatch and the sticky error can be forced on the cached instance.

// File: rtl/win_access_seq.sv
module win_access_seq #(
  parameter int          ADDR_W      = 25,
  parameter int          DATA_W      = 32,
  parameter int          WIN_SHIFT   = 19,
  parameter logic [31:0] WIN_REG_OFS = 32'h310C,
  parameter int          EN_BIT      = 30,
  parameter bit          CACHE_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              err_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_flag,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int              WIN_W     = ADDR_W - WIN_SHIFT;
  localparam logic [ADDR_W-1:0] AP_BASE   = ADDR_W'(1) << WIN_SHIFT;
  localparam logic [ADDR_W-1:0] RANGE_MSK = AP_BASE - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WIN_REG_A = ADDR_W'(WIN_REG_OFS);
  localparam logic [DATA_W-1:0] EN_WORD   = DATA_W'(1) << EN_BIT;

  typedef enum logic [1:0] {S_IDLE, S_WWR, S_WRD, S_DATA} st_t;
  st_t st;

  logic              r_wr, r_direct, cache_ok;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [WIN_W-1:0]  cache_win;

  wire [WIN_W-1:0]  req_win  = req_addr[ADDR_W-1:WIN_SHIFT];
  wire [WIN_W-1:0]  cur_win  = r_addr[ADDR_W-1:WIN_SHIFT];
  wire [DATA_W-1:0] win_word = EN_WORD | DATA_W'(cur_win);
  wire              direct   = !win_en || (req_win == '0);
  wire              hit      = CACHE_EN && cache_ok && (cache_win == req_win);

  assign req_ready = (st == S_IDLE);
  assign bus_valid = (st != S_IDLE);
  assign bus_write = (st == S_WWR) || (st == S_DATA && r_wr);
  assign bus_wdata = (st == S_WWR) ? win_word : r_wdata;
  assign bus_addr  = (st == S_WWR || st == S_WRD) ? WIN_REG_A :
                     r_direct ? r_addr : (AP_BASE | (r_addr & RANGE_MSK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      r_wr      <= 1'b0;
      r_direct  <= 1'b1;
      r_addr    <= '0;
      r_wdata   <= '0;
      cache_ok  <= 1'b0;
      cache_win <= '0;
      err_flag  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (err_clr) err_flag <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_wr     <= req_write;
          r_addr   <= req_addr;
          r_wdata  <= req_wdata;
          r_direct <= direct;
          st       <= (direct || hit) ? S_DATA : S_WWR;
        end
        S_WWR: if (bus_done) begin
          cache_win <= cur_win;
          cache_ok  <= 1'b1;
          st        <= S_WRD;
        end
        S_WRD: if (bus_done) begin
          if (bus_rdata != win_word) err_flag <= 1'b1;
          st <= S_DATA;
        end
        S_DATA: if (bus_done) begin
          rsp_valid <= 1'b1;
          if (!r_wr) rsp_rdata <= bus_rdata;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid);

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  a_r3_confirm_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == WIN_REG_A && bus_done && st == S_WWR
    |=> bus_valid && !bus_write && bus_addr == WIN_REG_A);

  a_r8_first_programs: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !cache_ok && !direct |=> bus_write && bus_addr == WIN_REG_A);

  a_r2_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WWR |-> bus_wdata[EN_BIT]);
endmodule

// File: tb/win_access_seq_test.sv
`timescale 1ns/1ps
module win_access_seq_test;
  localparam logic [24:0] WREG = 25'h310C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, win_en = 1'b1, err_clr = 1'b0;
  logic req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_valid [2];
  logic req_ready [2], rsp_valid [2], err_flag [2];
  logic [31:0] rsp_rdata [2];
  logic bus_valid [2], bus_write [2], bus_done [2];
  logic [24:0] bus_addr [2];
  logic [31:0] bus_wdata [2], bus_rdata [2];
  logic [31:0] winreg [2];
  logic [31:0] corrupt [2];

  logic [24:0] lg_addr [2][32];
  logic        lg_wr   [2][32];
  logic [31:0] lg_wd   [2][32];
  int          cnt     [2];

  int checks = 0, failures = 0;

  initial begin
    req_valid[0] = 1'b0; req_valid[1] = 1'b0;
    corrupt[0] = '0; corrupt[1] = '0;
  end

  win_access_seq #(.CACHE_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .err_clr(err_clr),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid[0]),
    .rsp_rdata(rsp_rdata[0]), .err_flag(err_flag[0]), .bus_valid(bus_valid[0]),
    .bus_write(bus_write[0]), .bus_addr(bus_addr[0]), .bus_wdata(bus_wdata[0]),
    .bus_done(bus_done[0]), .bus_rdata(bus_rdata[0]));

  win_access_seq #(.CACHE_EN(1'b0)) uut_nc (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .err_clr(err_clr),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid[1]),
    .rsp_rdata(rsp_rdata[1]), .err_flag(err_flag[1]), .bus_valid(bus_valid[1]),
    .bus_write(bus_write[1]), .bus_addr(bus_addr[1]), .bus_wdata(bus_wdata[1]),
    .bus_done(bus_done[1]), .bus_rdata(bus_rdata[1]));

  function automatic logic [31:0] mem_val(input logic [24:0] a);
    return 32'h5A00_0000 ^ {7'd0, a};
  endfunction

  assign bus_rdata[0] = (bus_addr[0] == WREG) ? (winreg[0] ^ corrupt[0]) : mem_val(bus_addr[0]);
  assign bus_rdata[1] = (bus_addr[1] == WREG) ? (winreg[1] ^ corrupt[1]) : mem_val(bus_addr[1]);

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        bus_done[i] <= 1'b0;
        winreg[i]   <= '0;
        cnt[i]      <= 0;
      end else begin
        bus_done[i] <= bus_valid[i] && !bus_done[i];
        if (bus_valid[i] && bus_done[i]) begin
          lg_addr[i][cnt[i] % 32] <= bus_addr[i];
          lg_wr[i][cnt[i] % 32]   <= bus_write[i];
          lg_wd[i][cnt[i] % 32]   <= bus_wdata[i];
          cnt[i] <= cnt[i] + 1;
          if (bus_write[i] && bus_addr[i] == WREG) winreg[i] <= bus_wdata[i];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_txn(input int sel, input int idx, input string req, input bit wr,
                         input logic [24:0] a, input logic [31:0] wd);
    logic [24:0] ga = lg_addr[sel][idx % 32];
    chk(ga == a, req, "bus address", 32'(ga), 32'(a));
    chk(lg_wr[sel][idx % 32] == wr, req, "bus direction",
        32'(lg_wr[sel][idx % 32]), 32'(wr));
    if (wr) chk(lg_wd[sel][idx % 32] == wd, req, "bus write data", lg_wd[sel][idx % 32], wd);
  endtask

  task automatic issue(input int sel, input bit wr, input logic [24:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int base, output int n);
    @(negedge clk);
    base = cnt[sel];
    req_write = wr; req_addr = a; req_wdata = wd; req_valid[sel] = 1'b1;
    while (!req_ready[sel]) @(negedge clk);
    @(negedge clk);
    req_valid[sel] = 1'b0;
    while (!rsp_valid[sel]) @(negedge clk);
    rd = rsp_rdata[sel];
    n = cnt[sel] - base;
    @(negedge clk);
    chk(!rsp_valid[sel], "R9", "response pulse length", 32'(rsp_valid[sel]), 32'd0);
  endtask

  function automatic logic [31:0] wword(input logic [24:0] a);
    return 32'h4000_0000 | {26'd0, a[24:19]};
  endfunction

  function automatic logic [24:0] apaddr(input logic [24:0] a);
    return 25'h80000 + (a & 25'h7FFFF);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready[0] == 1'b1, "R9", "ready after reset", 32'(req_ready[0]), 32'd1);
    chk(bus_valid[0] == 1'b0, "R9", "bus idle after reset", 32'(bus_valid[0]), 32'd0);
    chk(rsp_valid[0] == 1'b0, "R9", "no response after reset", 32'(rsp_valid[0]), 32'd0);
    chk(err_flag[0] == 1'b0, "R4", "error clear after reset", 32'(err_flag[0]), 32'd0);
  endtask

  task automatic t_direct();
    logic [31:0] rd; int b, n;
    issue(0, 1'b0, 25'h01234, '0, rd, b, n);
    chk(n == 1, "R1", "direct read access count", 32'(n), 32'd1);
    chk_txn(0, b, "R1", 1'b0, 25'h01234, '0);
    chk(rd == mem_val(25'h01234), "R9", "direct read data", rd, mem_val(25'h01234));
    issue(0, 1'b1, 25'h7FFFC, 32'hCAFE0001, rd, b, n);
    chk(n == 1, "R1", "direct write access count", 32'(n), 32'd1);
    chk_txn(0, b, "R1", 1'b1, 25'h7FFFC, 32'hCAFE0001);
  endtask

  task automatic t_first_window();
    logic [31:0] rd; int b, n;
    logic [24:0] a = 25'h0A80010;
    issue(0, 1'b0, a, '0, rd, b, n);
    chk(n == 3, "R8", "first windowed access count", 32'(n), 32'd3);
    chk_txn(0, b, "R2", 1'b1, WREG, wword(a));
    chk_txn(0, b + 1, "R3", 1'b0, WREG, '0);
    chk_txn(0, b + 2, "R7", 1'b0, apaddr(a), '0);
    chk(rd == mem_val(apaddr(a)), "R7", "windowed read data", rd, mem_val(apaddr(a)));
    chk(err_flag[0] == 1'b0, "R3", "no error on good readback", 32'(err_flag[0]), 32'd0);
  endtask

  task automatic t_cache_hit();
    logic [31:0] rd; int b, n;
    logic [24:0] a = 25'h0A9FFFC;
    issue(0, 1'b1, a, 32'h1234_5678, rd, b, n);
    chk(n == 1, "R5", "cache hit access count", 32'(n), 32'd1);
    chk_txn(0, b, "R5", 1'b1, apaddr(a), 32'h1234_5678);
  endtask

  task automatic t_win_off();
    logic [31:0] rd; int b, n;
    win_en = 1'b0;
    issue(0, 1'b0, 25'h1000040, '0, rd, b, n);
    chk(n == 1, "R1", "windowing off access count", 32'(n), 32'd1);
    chk_txn(0, b, "R1", 1'b0, 25'h1000040, '0);
    chk(rd == mem_val(25'h1000040), "R1", "windowing off read data", rd, mem_val(25'h1000040));
    win_en = 1'b1;
  endtask

  task automatic t_new_window();
    logic [31:0] rd; int b, n;
    logic [24:0] a = 25'h1FFFFFC;
    issue(0, 1'b1, a, 32'h0BAD_F00D, rd, b, n);
    chk(n == 3, "R2", "window change access count", 32'(n), 32'd3);
    chk_txn(0, b, "R2", 1'b1, WREG, 32'h4000_003F);
    chk_txn(0, b + 2, "R7", 1'b1, 25'hFFFFC, 32'h0BAD_F00D);
  endtask

  task automatic t_mismatch();
    logic [31:0] rd; int b, n;
    logic [24:0] a = 25'h0100000;
    corrupt[0] = 32'h0000_0001;
    issue(0, 1'b0, a, '0, rd, b, n);
    corrupt[0] = '0;
    chk(n == 3, "R3", "mismatch still completes access", 32'(n), 32'd3);
    chk_txn(0, b + 2, "R3", 1'b0, 25'h80000, '0);
    chk(err_flag[0] == 1'b1, "R3", "mismatch sets error", 32'(err_flag[0]), 32'd1);
    issue(0, 1'b0, 25'h00020, '0, rd, b, n);
    chk(err_flag[0] == 1'b1, "R4", "error stays set", 32'(err_flag[0]), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err_flag[0] == 1'b0, "R4", "error cleared", 32'(err_flag[0]), 32'd0);
  endtask

  task automatic t_no_cache();
    logic [31:0] rd; int b, n;
    logic [24:0] a = 25'h0A80010;
    for (int k = 0; k < 2; k++) begin
      issue(1, 1'b0, a, '0, rd, b, n);
      chk(n == 3, "R6", "uncached access count", 32'(n), 32'd3);
      chk_txn(1, b, "R6", 1'b1, WREG, wword(a));
      chk_txn(1, b + 1, "R6", 1'b0, WREG, '0);
      chk_txn(1, b + 2, "R6", 1'b0, apaddr(a), '0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_direct();
    t_first_window();
    t_cache_hit();
    t_win_off();
    t_new_window();
    t_mismatch();
    t_no_cache();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule